// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between an on-chip request port and an external asynchronous static RAM with a 16-bit word and two byte lanes. A requester presents an address, a write flag, write data and a per-byte enable mask. The block then runs one complete RAM access on the active-low chip-select, output-enable, write-strobe and byte-select pins. Read data comes back with a single-cycle valid strobe. The RAM has no clock, so each phase of an access is held for a number of clock cycles that is set by a parameter. Those counts are chosen from the clock period so that the RAM's minimum access, strobe-width and turnaround times are met.

The shared data lines are split into an output word, an input word and a drive-enable. The controller lets the RAM's output enable go high and waits a turnaround interval before it drives the lines. It keeps driving for one cycle after the write strobe rises, which covers data hold, and it releases the lines before output enable can fall again. A ready signal stays low for the whole of an access. While it is low, new requests are not taken.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset and while idle, the RAM pins are quiet: chip select, output enable and write strobe are high, every byte select is high, and the data drive-enable is low. The block also shows req_ready high and rsp_valid low.
- R2: A read drives chip select and output enable low and leaves the write strobe high. rsp_valid rises RD_CYC clock edges after the accepting edge and stays high for exactly one cycle.
- R3: Mask bit 0 enables byte lane bits 7:0 and mask bit 1 enables bits 15:8. In returned read data, an enabled lane carries the RAM's byte and a disabled lane reads as zero.
- R4: A write holds the write strobe low for exactly WR_CYC cycles. Before that come exactly TA_CYC cycles with chip select low and output enable high. ram_d_out equals the request's write data whenever the drive-enable is high.
- R5: During the write strobe, a byte select (ram_bsel_n bit 0 for the low byte, bit 1 for the high byte) is low only where the mask bit is 1. A masked-off byte in the RAM is left unchanged.
- R6: The data drive-enable is never high while output enable is low. It is high for WR_CYC+1 cycles per write and is still high in the cycle after the write strobe rises.
- R7: req_ready is low from the accepting edge until the access ends: RD_CYC cycles for a read and TA_CYC+WR_CYC+1 cycles for a write. A request presented while req_ready is low has no effect.
- R8: A request with an all-zero mask drives no byte select low. For a read, it still returns rsp_valid, with data zero.
- R9: ram_a holds the request address for every cycle in which chip select is low.
- R10: The write strobe is low only while chip select is low and output enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Word address |
| req_wdata | input | DATA_W (16) | Write data |
| req_mask | input | DATA_W/8 (2) | Byte enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W (16) | Read data, disabled lanes zero |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_rd_n | output | 1 | RAM output enable, active low |
| ram_wr_n | output | 1 | RAM write strobe, active low |
| ram_bsel_n | output | DATA_W/8 (2) | RAM byte selects, active low |
| ram_a | output | ADDR_W (16) | RAM address |
| ram_d_out | output | DATA_W (16) | Data toward the RAM |
| ram_d_in | input | DATA_W (16) | Data from the RAM |
| ram_d_drive | output | 1 | Drive-enable for ram_d_out |

## Verification
Each result has a fixed due cycle, counted from the edge that accepts the request.

- **Reads:** the access phase covers the next RD_CYC falling-edge samples. rsp_valid is due at sample RD_CYC+1 and must be gone at the sample after that.
- **Writes:** the first TA_CYC samples show output enable high with the strobe still high. The next WR_CYC samples show the strobe low. One more sample shows the hold cycle with the data still driven.

The bench counts samples from the accept edge, compares each count with these values, and compares the data only at the sample where it is due. The whole address space of a 64-word configuration is swept, and the mask sweep then exercises every byte-select combination.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared types for the static RAM bus controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sram_ctrl_pkg;

    // Access sequencer states; one RAM access runs through a subset of them.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_READ     = 3'd1,
        ST_WR_SETUP = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_HOLD  = 3'd4
    } ctrl_state_e;

    // Larger of three phase lengths, used to size the shared phase counter.
    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Module: sram_phase_timer
// Counts down the length of one access phase. A load sets the count to
// (phase length - 1); 'last' is high in the final cycle of the phase.
// Assumes: load is pulsed by the sequencer on entry to each phase.
module sram_phase_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Phase counter: load on phase entry, then count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

    // A load of zero must give a one-cycle phase; a non-zero load must not.
    p_timer_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (last == ($past(load_val) == '0)));

endmodule

// File: rtl/sram_lane_unit.sv
// Module: sram_lane_unit
// Per-byte-lane logic: active-low byte selects gated by the request mask,
// and the read capture register that zeroes lanes outside the mask.
// Assumes: DATA_W is a multiple of LANE_W; capture is a single-cycle pulse.
module sram_lane_unit #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_en,
    input  logic [LANES-1:0]  mask,
    input  logic              capture,
    input  logic [DATA_W-1:0] d_in,
    output logic [LANES-1:0]  bsel_n,
    output logic [DATA_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Byte select is asserted only inside a strobe phase and for an enabled lane.
        assign bsel_n[g] = ~(sel_en & mask[g]);

        // Read capture for this lane; a disabled lane returns zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdata[g*LANE_W +: LANE_W] <= '0;
            else if (capture)
                rdata[g*LANE_W +: LANE_W] <= mask[g] ? d_in[g*LANE_W +: LANE_W]
                                                     : '0;
        end
    end

    // An empty mask never asserts a byte select.
    p_empty_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> (&bsel_n));

    // Read data is captured only while the read strobe phase is active.
    p_capture_in_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> sel_en);

endmodule

// File: rtl/sram_bus_ctrl.sv
// Module: sram_bus_ctrl (top)
// Runs one asynchronous static RAM access per accepted request.
//   Read:  RD_CYC cycles with chip select and output enable low, data
//          captured on the last edge.
//   Write: TA_CYC turnaround cycles (output enable high, bus released),
//          WR_CYC strobe cycles with data driven, then one hold cycle
//          with the strobe high and data still driven.
// Assumes: RD_CYC, WR_CYC, TA_CYC >= 1 and chosen from the clock period to
// meet the RAM's minimum times; RAM control pins are active low.
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned RD_CYC = 2,
    parameter int unsigned WR_CYC = 1,
    parameter int unsigned TA_CYC = 1,
    localparam int unsigned LANES  = DATA_W / 8,
    localparam int unsigned MAXCYC = max3(RD_CYC, WR_CYC, TA_CYC),
    localparam int unsigned CNT_W  = (MAXCYC < 2) ? 1 : $clog2(MAXCYC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ram_cs_n,
    output logic              ram_rd_n,
    output logic              ram_wr_n,
    output logic [LANES-1:0]  ram_bsel_n,
    output logic [ADDR_W-1:0] ram_a,
    output logic [DATA_W-1:0] ram_d_out,
    input  logic [DATA_W-1:0] ram_d_in,
    output logic              ram_d_drive
);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);

    ctrl_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic              rsp_q;
    logic              accept;
    logic              t_load;
    logic [CNT_W-1:0]  t_val;
    logic              t_last;
    logic              capture;
    logic              sel_en;

    assign accept  = req_valid && (state_q == ST_IDLE);
    assign capture = (state_q == ST_READ) && t_last;

    // Next-state and phase-timer load selection.
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                t_load  = 1'b1;
                if (req_write) begin
                    state_d = ST_WR_SETUP;
                    t_val   = TA_LOAD;
                end else begin
                    state_d = ST_READ;
                    t_val   = RD_LOAD;
                end
            end
            ST_READ:     if (t_last) state_d = ST_IDLE;
            ST_WR_SETUP: if (t_last) begin
                state_d = ST_WR_PULSE;
                t_load  = 1'b1;
                t_val   = WR_LOAD;
            end
            ST_WR_PULSE: if (t_last) state_d = ST_WR_HOLD;
            ST_WR_HOLD:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture: address, data and mask held for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    // One-cycle read-valid strobe, raised on the capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= 1'b0;
        else        rsp_q <= capture;
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    assign sel_en = (state_q == ST_READ) || (state_q == ST_WR_PULSE);

    sram_lane_unit #(.DATA_W(DATA_W), .LANE_W(8)) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_en  (sel_en),
        .mask    (mask_q),
        .capture (capture),
        .d_in    (ram_d_in),
        .bsel_n  (ram_bsel_n),
        .rdata   (rsp_rdata)
    );

    // RAM pin decode from the registered state: glitch-free, one level deep.
    assign ram_cs_n    = (state_q == ST_IDLE);
    assign ram_rd_n    = (state_q != ST_READ);
    assign ram_wr_n    = (state_q != ST_WR_PULSE);
    assign ram_d_drive = (state_q == ST_WR_PULSE) || (state_q == ST_WR_HOLD);
    assign ram_a       = addr_q;
    assign ram_d_out   = wdata_q;
    assign req_ready   = (state_q == ST_IDLE);
    assign rsp_valid   = rsp_q;

    // Deselected RAM sees no strobes and no driven data.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs_n |-> (ram_rd_n && ram_wr_n && (&ram_bsel_n) && !ram_d_drive));

    // Read-valid is a single-cycle pulse.
    p_rsp_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // The strobe falls only after a cycle with the RAM selected and its outputs off.
    p_setup_before_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_wr_n) |-> ($past(ram_rd_n) && !$past(ram_cs_n)));

    // Never drive the data lines while the RAM may drive them.
    p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_d_drive |-> ram_rd_n);

    // Data is still driven in the cycle after the strobe rises (hold).
    p_hold_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_wr_n) |-> ram_d_drive);

    // An accepted request makes the controller busy on the next cycle.
    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // The address stays put while the RAM remains selected.
    p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_cs_n && !$past(ram_cs_n)) |-> $stable(ram_a));

    // Write strobe only with chip selected and RAM outputs disabled.
    p_strobe_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_wr_n |-> (!ram_cs_n && ram_rd_n));

endmodule

// File: tb/tb_sram_bus_ctrl.sv
module tb_sram_bus_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 6;
    localparam int DW  = 16;
    localparam int RDC = 3;
    localparam int WRC = 2;
    localparam int TAC = 1;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    req_mask = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          ram_cs_n, ram_rd_n, ram_wr_n, ram_d_drive;
    logic [1:0]    ram_bsel_n;
    logic [AW-1:0] ram_a;
    logic [DW-1:0] ram_d_out, ram_d_in;

    int checks = 0;
    int errors = 0;
    int conflicts = 0;
    bit finished = 0;

    logic [DW-1:0] mem  [WORDS];
    logic [DW-1:0] shad [WORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RDC), .WR_CYC(WRC),
                    .TA_CYC(TAC)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_cs_n(ram_cs_n), .ram_rd_n(ram_rd_n), .ram_wr_n(ram_wr_n),
        .ram_bsel_n(ram_bsel_n), .ram_a(ram_a), .ram_d_out(ram_d_out),
        .ram_d_in(ram_d_in), .ram_d_drive(ram_d_drive));

    // RAM model: selected lanes drive stored data during a read; floating lanes show junk.
    wire rd_on = !ram_cs_n && !ram_rd_n && ram_wr_n;
    assign ram_d_in[7:0]  = (rd_on && !ram_bsel_n[0]) ? mem[ram_a][7:0]  : 8'hEE;
    assign ram_d_in[15:8] = (rd_on && !ram_bsel_n[1]) ? mem[ram_a][15:8] : 8'hDD;

    // RAM write model and bus-conflict monitor, sampled away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_d_drive && !ram_rd_n) conflicts++;
            if (!ram_wr_n && (ram_cs_n || !ram_rd_n || !ram_d_drive)) conflicts++;
            if (!ram_cs_n && !ram_wr_n) begin
                if (!ram_bsel_n[0]) mem[ram_a][7:0]  = ram_d_out[7:0];
                if (!ram_bsel_n[1]) mem[ram_a][15:8] = ram_d_out[15:8];
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic [1:0] m);
        return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
    endfunction

    // Write: count turnaround, strobe, drive and busy cycles from the accept edge.
    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d,
                            input logic [1:0] m, input bit detail);
        int busy = 0, strobe = 0, setup = 0, drv = 0, abad = 0, lbad = 0, dbad = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 0;
        while (!req_ready && busy < 64) begin
            busy++;
            if (!ram_wr_n) begin
                strobe++;
                if (ram_bsel_n != ~m) lbad++;
            end else if (strobe == 0 && ram_rd_n && !ram_cs_n) setup++;
            if (ram_d_drive) begin
                drv++;
                if (ram_d_out != d) dbad++;
            end
            if (ram_a != a) abad++;
            @(negedge clk);
        end
        shad[a] = merge(shad[a], d, m);
        check(lbad == 0, "R5 byte selects during strobe", lbad, 0);
        check(mem[a] == shad[a], "R5 RAM contents after write", mem[a], shad[a]);
        if (detail) begin
            check(strobe == WRC, "R4 strobe cycles", strobe, WRC);
            check(setup == TAC, "R4 turnaround cycles", setup, TAC);
            check(dbad == 0, "R4 driven data", dbad, 0);
            check(drv == WRC + 1, "R6 drive cycles", drv, WRC + 1);
            check(busy == TAC + WRC + 1, "R7 write busy cycles", busy, TAC + WRC + 1);
            check(abad == 0, "R9 address held", abad, 0);
        end
    endtask

    // Read: rsp_valid due at sample RDC+1 after accept, gone one sample later.
    task automatic do_read(input logic [AW-1:0] a, input logic [1:0] m,
                           input bit detail, input bit poke);
        int busy = 0, early = 0, abad = 0, selbad = 0;
        logic [15:0] exp;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_mask = m;
        @(negedge clk);
        req_valid = 0;
        while (!req_ready && busy < 64) begin
            busy++;
            if (rsp_valid) early++;
            if (ram_a != a) abad++;
            if (ram_bsel_n != ~m || ram_rd_n || !ram_wr_n) selbad++;
            // R7: a write offered while busy must be ignored.
            if (poke && busy == 1) begin
                req_valid = 1; req_write = 1; req_addr = a ^ 6'h01;
                req_wdata = 16'hBAD0; req_mask = 2'b11;
            end
            if (poke && busy == RDC) req_valid = 0;
            @(negedge clk);
        end
        exp = {m[1] ? shad[a][15:8] : 8'h00, m[0] ? shad[a][7:0] : 8'h00};
        check(rsp_valid === 1'b1 && early == 0, "R2 rsp_valid timing", busy, RDC);
        check(rsp_rdata == exp, "R3 read data lanes", rsp_rdata, exp);
        if (m == 2'b00) check(rsp_rdata == 16'h0, "R8 empty-mask read data", rsp_rdata, 0);
        if (detail) begin
            check(busy == RDC, "R7 read busy cycles", busy, RDC);
            check(selbad == 0, "R2 read strobes and selects", selbad, 0);
            check(abad == 0, "R9 read address held", abad, 0);
        end
        @(negedge clk);
        if (detail) check(rsp_valid == 1'b0, "R2 rsp_valid one cycle", rsp_valid, 0);
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mem[i]  = 16'hC000 | 16'(i);
            shad[i] = 16'hC000 | 16'(i);
        end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 idle state after reset
        check(ram_cs_n && ram_rd_n && ram_wr_n && ram_bsel_n == 2'b11 && !ram_d_drive,
              "R1 idle RAM pins", {ram_cs_n, ram_rd_n, ram_wr_n, ram_bsel_n, ram_d_drive},
              6'b111110);
        check(req_ready && !rsp_valid, "R1 idle handshake", {req_ready, rsp_valid}, 2'b10);

        // Full sweep: write every word with full mask, read each back.
        for (int i = 0; i < WORDS; i++)
            do_write(AW'(i), 16'((i * 16'h0351) ^ 16'h5A3C), 2'b11, i < 4);
        for (int i = 0; i < WORDS; i++)
            do_read(AW'(i), 2'b11, i < 4, 1'b0);

        // Mask sweep: every write mask against every read mask.
        for (int a = 0; a < 8; a++) begin
            for (int wm = 0; wm < 4; wm++) begin
                do_write(AW'(a), 16'(16'h1111 * (wm + 1) + a), 2'(wm), a == 0);
                for (int rm = 0; rm < 4; rm++)
                    do_read(AW'(a), 2'(rm), a == 0, 1'b0);
            end
        end

        // R8 empty-mask write leaves the word untouched.
        do_write(6'd20, 16'hFFFF, 2'b00, 1'b1);
        check(mem[20] == shad[20], "R8 empty-mask write", mem[20], shad[20]);

        // R7 request offered while busy is ignored.
        do_read(6'd30, 2'b11, 1'b1, 1'b1);
        @(negedge clk);
        check(ram_cs_n == 1'b1, "R7 no extra access", ram_cs_n, 1);
        check(mem[31] == shad[31], "R7 ignored write", mem[31], shad[31]);
        do_read(6'd31, 2'b11, 1'b0, 1'b0);

        check(conflicts == 0, "R6 R10 bus conflicts", conflicts, 0);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule